// File: doc/BRIEF.md
# Serial Host Control Port

This block is a slave serial port that lets a host load and inspect a word-addressed register file. It uses one serial clock line and one data line that both sides share. The host opens a frame with an in-band attention marker on the data line, then sends a select bit, a direction bit and an 8-bit word address. On a write, 32-bit words follow and land at consecutive addresses. On a read, the port releases the line for a fixed gap, fetches one word and shifts it back out to the host.

The serial lines are asynchronous to the system clock. They pass through a two-flop synchroniser, and a bit is taken on each rising edge of the serial clock. Word addresses 0 to 127 reach the instruction store. Word 128 is the first control/status word and word 129 is the second. No other address reaches any target. This block covers framing, address stepping and data-line direction. What the registers hold is outside its scope.

Top module: `sci_host_port`

## Requirements
- R1: After reset the data-line enable `sdata_oe_o` is 0, `sdata_o` is 0, and no write strobe and no read request is raised.
- R2: A frame opens only after the data line is sampled as 0, 1, 0 on three consecutive rising serial-clock edges and the next sampled bit is 0 (select). If that next bit is 1 (deselect), the port returns to hunting and later bits cause no strobe or drive.
- R3: After select, one direction bit follows (1 = write, 0 = read), then the 8-bit word address, most significant bit first.
- R4: On a write, each 32 serial bits after the address form one word, most significant bit first. The word is presented on `wdata_o` with a one-cycle strobe for its target, and `addr_o` holds the word's address.
- R5: Within a write frame the word address steps by one after every complete word, so consecutive words go to consecutive addresses.
- R6: Address decode works as follows. Addresses 0 to 127 pulse `wr_instr_o`, 128 pulses `wr_cs0_o` and 129 pulses `wr_cs1_o`. Addresses 130 to 255 raise no strobe and no `rd_req_o`, and a read there returns all zero bits.
- R7: On a read to a mapped address, `rd_req_o` pulses for one cycle after the last address bit. `sdata_oe_o` stays 0 for at least TURN_CYC (default 8) system clocks from that pulse. `rd_data_i` is then captured and its bit 31 is driven.
- R8: While read data is driven, each rising serial-clock edge moves the output to the next lower bit. After the 32nd edge the port releases the line (`sdata_oe_o` = 0) and hunts for a new frame. No write strobe occurs while the line is driven.
- R9: At the start of each write word, a 0, 1, 0 marker ends the current word stream. A following 1 closes the frame. A following 0 starts a new frame whose next bit is the direction bit. The marker bits are never written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sclk_i | input | 1 | Serial clock from host |
| sdata_i | input | 1 | Data line as seen at the pad input |
| sdata_o | output | 1 | Data bit driven toward the pad |
| sdata_oe_o | output | 1 | Pad output enable for the data line |
| addr_o | output | 8 | Current word address |
| wdata_o | output | 32 | Write word |
| wr_instr_o | output | 1 | Write strobe, instruction store |
| wr_cs0_o | output | 1 | Write strobe, control/status word 0 |
| wr_cs1_o | output | 1 | Write strobe, control/status word 1 |
| rd_req_o | output | 1 | Read request for `addr_o` |
| rd_data_i | input | 32 | Read word, valid TURN_CYC clocks after `rd_req_o` |

## Verification
The port acts on a rising serial-clock edge on the third system clock after that edge. Two synchroniser flops and one edge flop lie on that path. Write strobes and read requests appear one clock after the port acts, and the read line is driven TURN_CYC clocks after the request. The bench holds every serial-clock phase for at least three system clocks. It checks strobes through a monitor that logs every strobe cycle, and it samples the data line and its enable at falling system-clock edges, only after the serial phase that produced them has settled. It checks that the line is still released partway into the turnaround and driven once the gap has passed.

// File: rtl/sci_pkg.sv
package sci_pkg;
  typedef enum logic [2:0] {
    ST_HUNT, ST_SEL, ST_DIR, ST_ADDR, ST_WDATA, ST_TURN, ST_RDATA
  } sci_state_e;

  typedef enum logic [1:0] {
    TGT_NONE, TGT_INSTR, TGT_CS0, TGT_CS1
  } sci_tgt_e;

  localparam logic [2:0] ATTN_PAT = 3'b010;
endpackage

// File: rtl/sci_sync.sv
module sci_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sclk_i,
  input  logic sdata_i,
  output logic bit_vld_o,
  output logic bit_val_o
);
  logic [1:0] sclk_s, sdat_s;
  logic       sclk_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_s <= '0;
      sdat_s <= '0;
      sclk_d <= 1'b0;
    end else begin
      sclk_s <= {sclk_s[0], sclk_i};
      sdat_s <= {sdat_s[0], sdata_i};
      sclk_d <= sclk_s[1];
    end
  end

  // data and clock share sync depth, so data is aligned to the edge
  assign bit_vld_o = sclk_s[1] & ~sclk_d;
  assign bit_val_o = sdat_s[1];
endmodule

// File: rtl/sci_decode.sv
module sci_decode import sci_pkg::*; #(
  parameter int AW          = 8,
  parameter int INSTR_WORDS = 128
) (
  input  logic [AW-1:0] addr_i,
  output sci_tgt_e      tgt_o
);
  localparam logic [AW-1:0] CS0_ADDR = AW'(INSTR_WORDS);
  localparam logic [AW-1:0] CS1_ADDR = AW'(INSTR_WORDS + 1);

  always_comb begin
    if (addr_i < CS0_ADDR)       tgt_o = TGT_INSTR;
    else if (addr_i == CS0_ADDR) tgt_o = TGT_CS0;
    else if (addr_i == CS1_ADDR) tgt_o = TGT_CS1;
    else                         tgt_o = TGT_NONE;
  end
endmodule

// File: rtl/sci_frame.sv
module sci_frame import sci_pkg::*; #(
  parameter int AW       = 8,
  parameter int DW       = 32,
  parameter int TURN_CYC = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          bit_vld_i,
  input  logic          bit_val_i,
  input  logic          mapped_i,
  input  logic [DW-1:0] rd_data_i,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] wdata_o,
  output logic          wr_stb_o,
  output logic          rd_stb_o,
  output logic          sdata_o,
  output logic          sdata_oe_o
);
  localparam int CW = $clog2(DW);
  localparam int TW = $clog2(TURN_CYC + 1);

  sci_state_e    st_q;
  logic [2:0]    hist_q;
  logic [CW-1:0] cnt_q;
  logic [TW-1:0] tcnt_q;
  logic          wr_mode_q;
  logic [DW-1:0] wsh_q, rsh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_HUNT;
      hist_q     <= 3'b111;
      cnt_q      <= '0;
      tcnt_q     <= '0;
      wr_mode_q  <= 1'b0;
      wsh_q      <= '0;
      rsh_q      <= '0;
      addr_o     <= '0;
      wdata_o    <= '0;
      wr_stb_o   <= 1'b0;
      rd_stb_o   <= 1'b0;
      sdata_oe_o <= 1'b0;
    end else begin
      wr_stb_o <= 1'b0;
      rd_stb_o <= 1'b0;
      if (wr_stb_o) addr_o <= addr_o + 1'b1;

      if (st_q == ST_TURN) begin
        if (tcnt_q == TW'(TURN_CYC - 1)) begin
          rsh_q      <= mapped_i ? rd_data_i : '0;
          sdata_oe_o <= 1'b1;
          cnt_q      <= '0;
          st_q       <= ST_RDATA;
        end else begin
          tcnt_q <= tcnt_q + 1'b1;
        end
      end

      if (bit_vld_i) begin
        hist_q <= {hist_q[1:0], bit_val_i};
        unique case (st_q)
          ST_HUNT: if (hist_q[1:0] == ATTN_PAT[2:1] && bit_val_i == ATTN_PAT[0])
            st_q <= ST_SEL;
          ST_SEL: begin
            st_q   <= bit_val_i ? ST_HUNT : ST_DIR;
            hist_q <= 3'b111;
          end
          ST_DIR: begin
            wr_mode_q <= bit_val_i;
            cnt_q     <= '0;
            st_q      <= ST_ADDR;
          end
          ST_ADDR: begin
            addr_o <= {addr_o[AW-2:0], bit_val_i};
            if (cnt_q == CW'(AW - 1)) begin
              cnt_q <= '0;
              if (wr_mode_q) st_q <= ST_WDATA;
              else begin
                st_q     <= ST_TURN;
                tcnt_q   <= '0;
                rd_stb_o <= 1'b1;
              end
            end else cnt_q <= cnt_q + 1'b1;
          end
          ST_WDATA: begin
            // marker only recognised in the first three bits of a word
            if (cnt_q == CW'(3) && wsh_q[2:0] == ATTN_PAT) begin
              st_q   <= bit_val_i ? ST_HUNT : ST_DIR;
              cnt_q  <= '0;
              hist_q <= 3'b111;
            end else begin
              wsh_q <= {wsh_q[DW-2:0], bit_val_i};
              if (cnt_q == CW'(DW - 1)) begin
                wdata_o  <= {wsh_q[DW-2:0], bit_val_i};
                wr_stb_o <= 1'b1;
                cnt_q    <= '0;
              end else cnt_q <= cnt_q + 1'b1;
            end
          end
          ST_RDATA: begin
            rsh_q <= {rsh_q[DW-2:0], 1'b0};
            if (cnt_q == CW'(DW - 1)) begin
              sdata_oe_o <= 1'b0;
              st_q       <= ST_HUNT;
              hist_q     <= 3'b111;
            end else cnt_q <= cnt_q + 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  assign sdata_o = sdata_oe_o & rsh_q[DW-1];

  // turnaround gap watcher
  logic [TW-1:0] gap_q;
  logic          gap_run_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q     <= '0;
      gap_run_q <= 1'b0;
    end else if (rd_stb_o) begin
      gap_q     <= TW'(1);
      gap_run_q <= 1'b1;
    end else if (gap_run_q && gap_q < TW'(TURN_CYC)) begin
      gap_q <= gap_q + 1'b1;
    end else begin
      gap_run_q <= 1'b0;
    end
  end

  AST_TURN_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_stb_o || (gap_run_q && gap_q < TW'(TURN_CYC))) |-> !sdata_oe_o); // R7
  AST_NO_WR_WHILE_DRIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sdata_oe_o |-> !wr_stb_o); // R8
  AST_STB_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_stb_o && rd_stb_o)); // R4
endmodule

// File: rtl/sci_host_port.sv
module sci_host_port import sci_pkg::*; #(
  parameter int AW          = 8,
  parameter int DW          = 32,
  parameter int INSTR_WORDS = 128,
  parameter int TURN_CYC    = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sclk_i,
  input  logic          sdata_i,
  output logic          sdata_o,
  output logic          sdata_oe_o,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] wdata_o,
  output logic          wr_instr_o,
  output logic          wr_cs0_o,
  output logic          wr_cs1_o,
  output logic          rd_req_o,
  input  logic [DW-1:0] rd_data_i
);
  logic     bit_vld, bit_val, wr_stb, rd_stb, mapped;
  sci_tgt_e tgt;

  sci_sync u_sync (
    .clk_i, .rst_ni, .sclk_i, .sdata_i,
    .bit_vld_o(bit_vld), .bit_val_o(bit_val)
  );

  sci_decode #(.AW(AW), .INSTR_WORDS(INSTR_WORDS)) u_dec (
    .addr_i(addr_o), .tgt_o(tgt)
  );

  assign mapped = (tgt != TGT_NONE);

  sci_frame #(.AW(AW), .DW(DW), .TURN_CYC(TURN_CYC)) u_frame (
    .clk_i, .rst_ni,
    .bit_vld_i(bit_vld), .bit_val_i(bit_val), .mapped_i(mapped),
    .rd_data_i, .addr_o, .wdata_o,
    .wr_stb_o(wr_stb), .rd_stb_o(rd_stb),
    .sdata_o, .sdata_oe_o
  );

  assign wr_instr_o = wr_stb & (tgt == TGT_INSTR);
  assign wr_cs0_o   = wr_stb & (tgt == TGT_CS0);
  assign wr_cs1_o   = wr_stb & (tgt == TGT_CS1);
  assign rd_req_o   = rd_stb & mapped;

  AST_WR_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({wr_instr_o, wr_cs0_o, wr_cs1_o})); // R6
  AST_INSTR_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_instr_o |-> (addr_o < AW'(INSTR_WORDS))); // R6
  AST_ADDR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_stb |=> (addr_o == AW'($past(addr_o) + 1'b1))); // R5
endmodule

// File: tb/sim_sci_host_port.sv
module sim_sci_host_port;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n, sclk, sdat;
  logic        sdata_o, sdata_oe, wr_instr, wr_cs0, wr_cs1, rd_req;
  logic [7:0]  addr;
  logic [31:0] wdata, rd_data;

  int tests = 0, fails = 0;
  bit done = 1'b0;

  assign rd_data = {addr, 8'hA5, ~addr, 8'h3C};

  sci_host_port u0 (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .sdata_i(sdat),
    .sdata_o(sdata_o), .sdata_oe_o(sdata_oe), .addr_o(addr), .wdata_o(wdata),
    .wr_instr_o(wr_instr), .wr_cs0_o(wr_cs0), .wr_cs1_o(wr_cs1),
    .rd_req_o(rd_req), .rd_data_i(rd_data)
  );

  // strobe log: tgt 1=instr 2=cs0 4=cs1
  int          n_wr = 0, n_rd = 0;
  logic [7:0]  la [16];
  logic [31:0] ld [16];
  logic [2:0]  lt [16];
  always @(posedge clk) begin
    if (rst_n && (wr_instr || wr_cs0 || wr_cs1)) begin
      if (n_wr < 16) begin
        la[n_wr] <= addr;
        ld[n_wr] <= wdata;
        lt[n_wr] <= {wr_cs1, wr_cs0, wr_instr};
      end
      n_wr <= n_wr + 1;
    end
    if (rst_n && rd_req) n_rd <= n_rd + 1;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic sbit(input logic b);
    @(negedge clk) sdat = b;
    repeat (3) @(negedge clk);
    sclk = 1'b1;
    repeat (4) @(negedge clk);
    sclk = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic attn();
    sbit(1'b0); sbit(1'b1); sbit(1'b0);
  endtask

  task automatic hdr(input logic rw, input logic [7:0] a);
    attn();
    sbit(1'b0);
    sbit(rw);
    for (int i = 7; i >= 0; i--) sbit(a[i]);
  endtask

  task automatic word(input logic [31:0] d);
    for (int i = 31; i >= 0; i--) sbit(d[i]);
  endtask

  task automatic close_frame();
    attn();
    sbit(1'b1);
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    check("R1 oe", {31'b0, sdata_oe}, 32'd0);
    check("R1 sdata", {31'b0, sdata_o}, 32'd0);
    check("R1 strobes", n_wr + n_rd, 32'd0);
  endtask

  task automatic t_single_write();
    int b = n_wr;
    hdr(1'b1, 8'h05);
    word(32'hDEADBEEF);
    close_frame();
    check("R4 count", n_wr - b, 32'd1);
    check("R3 addr", {24'b0, la[b]}, 32'h05);
    check("R4 data", ld[b], 32'hDEADBEEF);
    check("R6 instr tgt", {29'b0, lt[b]}, 32'd1);
  endtask

  task automatic t_autoinc();
    int b = n_wr;
    hdr(1'b1, 8'h7F);
    word(32'h80000001);
    word(32'h92345678);
    word(32'hF0F00F0F);
    word(32'hC0000000); // lands on 0x82, unmapped
    close_frame();
    check("R6 unmapped no strobe", n_wr - b, 32'd3);
    check("R5 addr0", {24'b0, la[b]}, 32'h7F);
    check("R5 addr1", {24'b0, la[b+1]}, 32'h80);
    check("R5 addr2", {24'b0, la[b+2]}, 32'h81);
    check("R6 cs0 tgt", {29'b0, lt[b+1]}, 32'd2);
    check("R6 cs1 tgt", {29'b0, lt[b+2]}, 32'd4);
    check("R5 data2", ld[b+2], 32'hF0F00F0F);
  endtask

  task automatic t_deselect();
    int b = n_wr, r = n_rd;
    attn();
    sbit(1'b1);
    for (int i = 0; i < 44; i++) sbit(1'b1);
    repeat (4) @(negedge clk);
    check("R2 deselect no write", n_wr - b, 32'd0);
    check("R2 deselect no read", n_rd - r, 32'd0);
    check("R2 deselect no drive", {31'b0, sdata_oe}, 32'd0);
  endtask

  task automatic t_boundary();
    int b = n_wr;
    hdr(1'b1, 8'h10);
    word(32'hC1C2C3C4);
    attn();
    sbit(1'b0);          // select: new frame
    sbit(1'b1);          // write
    for (int i = 7; i >= 0; i--) sbit(8'h20 >> i);
    word(32'hE5E6E7E8);
    close_frame();
    check("R9 count", n_wr - b, 32'd2);
    check("R9 first addr", {24'b0, la[b]}, 32'h10);
    check("R9 restart addr", {24'b0, la[b+1]}, 32'h20);
    check("R9 restart data", ld[b+1], 32'hE5E6E7E8);
  endtask

  task automatic t_read(input logic [7:0] a, input bit mapped);
    int r = n_rd, b = n_wr;
    logic [31:0] exp;
    exp = mapped ? {a, 8'hA5, ~a, 8'h3C} : 32'h0;
    hdr(1'b0, a);
    check("R7 gap released", {31'b0, sdata_oe}, 32'd0);
    check("R7 rd_req", n_rd - r, mapped ? 32'd1 : 32'd0);
    repeat (10) @(negedge clk);
    check("R7 driven", {31'b0, sdata_oe}, 32'd1);
    for (int i = 31; i >= 0; i--) begin
      check("R8 bit", {31'b0, sdata_o}, {31'b0, exp[i]});
      sbit(1'b1);
    end
    check("R8 released", {31'b0, sdata_oe}, 32'd0);
    check("R8 no write", n_wr - b, 32'd0);
  endtask

  initial begin
    rst_n = 1'b0; sclk = 1'b0; sdat = 1'b1;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_single_write();
    t_autoinc();
    t_deselect();
    t_boundary();
    t_read(8'h81, 1'b1);
    t_read(8'h2A, 1'b1);
    t_read(8'h90, 1'b0);
    t_single_write();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule